// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block gathers sector-erase requests into one erase operation. The first sector-erase command opens an acceptance window. Each later command that arrives while the window is open adds its sector to a pending mask and restarts the window timer. If the timer runs out with no new command, the window closes. A status bit then goes high, and a one-cycle start pulse hands the collected mask to the erase engine.

While the erase runs, every command is ignored. The block stays in this state until the engine reports that it has finished. A busy flag goes high in the cycle after the first command, so status polling is valid from that point on, not only once the window closes. A command that names a protected sector still opens or restarts the window, but that sector is never added to the mask. If the window closes with an empty mask, the block returns to idle without starting an erase.

The window length is set in clock cycles. The integrator must choose a value that covers at least 80 µs at the clock rate in use.

Top module: `sector_erase_window`

## Requirements
- R1: After reset is asserted, `sector_mask` is all zeros and `timer_closed`, `busy` and `erase_start` are all 0.
- R2: In idle, a command sampled with `cmd_valid` = 1 sets `busy` to 1 in the next cycle, while `timer_closed` stays 0.
- R3: While the window is open, a command for an unprotected sector i sets bit i of `sector_mask` in the next cycle and keeps all bits already set. Sector i corresponds to bit i of `protect_map` and bit i of `sector_mask`.
- R4: The window closes on the WINDOW_CYCLES-th clock edge after the last accepted command, provided no command arrives in between. A command at exactly that edge is still accepted and restarts the window. When the window closes with a non-empty mask, `timer_closed` goes to 1 and `erase_start` is 1 for exactly that first closed cycle.
- R5: While `timer_closed` is 1, commands have no effect and `sector_mask` holds its value.
- R6: `erase_done` sampled while `timer_closed` is 1 returns the block to idle in the next cycle: `busy` = 0, `timer_closed` = 0 and `sector_mask` = 0.
- R7: A command for a sector whose `protect_map` bit is 1 does not set that sector's mask bit. It does open or restart the window.
- R8: A window that closes with an empty mask produces no `erase_start` and returns the block to idle.
- R9: `erase_done` has no effect while the block is idle or the window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe for a completed sector-erase command |
| cmd_sector | input | $clog2(N_SECTORS) | Sector index of the command |
| protect_map | input | N_SECTORS | Bit i = 1 marks sector i as protected |
| erase_done | input | 1 | Erase engine has finished |
| timer_closed | output | 1 | 0 while the window is open or idle; 1 once the erase has begun |
| busy | output | 1 | An erase sequence is in progress (window open or erasing) |
| sector_mask | output | N_SECTORS | Sectors queued for the erase |
| erase_start | output | 1 | One-cycle pulse that launches the erase |

## Verification
A counter that restarts wrongly or runs off by one moves the rising edge of `timer_closed` and `erase_start` by at least one cycle. The per-clock comparison therefore exposes it on the edge where the window should close. A corrupted mask shows up in `sector_mask` in the cycle after the offending command. A state that leaks past an erase or a reset shows up as `busy` or a non-zero mask one cycle after `erase_done` or reset.

// File: rtl/sector_erase_window.sv
`timescale 1ns/1ps
module sector_erase_window #(
  parameter int N_SECTORS     = 16,
  parameter int WINDOW_CYCLES = 16000,
  localparam int SEC_W = $clog2(N_SECTORS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [SEC_W-1:0]     cmd_sector,
  input  logic [N_SECTORS-1:0] protect_map,
  input  logic                 erase_done,
  output logic                 timer_closed,
  output logic                 busy,
  output logic [N_SECTORS-1:0] sector_mask,
  output logic                 erase_start
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_ERASE} state_t;

  state_t               state;
  logic [CNT_W-1:0]     cnt;
  logic [N_SECTORS-1:0] add_bit;

  assign add_bit      = ({{(N_SECTORS-1){1'b0}}, 1'b1} << cmd_sector) & ~protect_map;
  assign busy         = (state != S_IDLE);
  assign timer_closed = (state == S_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sector_mask <= '0;
      erase_start <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          state       <= S_OPEN;
          cnt         <= '0;
          sector_mask <= add_bit;
        end
        S_OPEN: begin
          if (cmd_valid) begin
            cnt         <= '0;
            sector_mask <= sector_mask | add_bit;
          end else if (cnt == LAST) begin
            if (|sector_mask) begin
              state       <= S_ERASE;
              erase_start <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ERASE: if (erase_done) begin
          state       <= S_IDLE;
          sector_mask <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_erase_window_chk.sv
`timescale 1ns/1ps
module sector_erase_window_chk #(
  parameter int N_SECTORS = 16,
  localparam int SEC_W = $clog2(N_SECTORS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [SEC_W-1:0]     cmd_sector,
  input logic [N_SECTORS-1:0] protect_map,
  input logic                 erase_done,
  input logic                 timer_closed,
  input logic                 busy,
  input logic [N_SECTORS-1:0] sector_mask,
  input logic                 erase_start
);
  p_idle_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sector_mask == '0 && !timer_closed));

  p_closed_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timer_closed |-> busy);

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_start_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> timer_closed);

  p_mask_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_closed && !erase_done) |=> (timer_closed && $stable(sector_mask)));

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_closed && erase_done) |=> (!busy && sector_mask == '0));

  p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !timer_closed && protect_map[cmd_sector])
      |=> (sector_mask[$past(cmd_sector)] == $past(sector_mask[cmd_sector])));

  p_start_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (sector_mask != '0));

  p_done_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !timer_closed && erase_done) |=> busy);
endmodule

bind sector_erase_window sector_erase_window_chk #(.N_SECTORS(N_SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sector(cmd_sector),
  .protect_map(protect_map), .erase_done(erase_done), .timer_closed(timer_closed),
  .busy(busy), .sector_mask(sector_mask), .erase_start(erase_start)
);

// File: tb/sector_erase_window_tb.sv
`timescale 1ns/1ps
module sector_erase_window_tb;
  localparam int N = 8;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_sector = '0;
  logic [N-1:0] protect_map = '0;
  logic         erase_done = 1'b0;
  logic         timer_closed, busy, erase_start;
  logic [N-1:0] sector_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sector_erase_window #(.N_SECTORS(N), .WINDOW_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sector(cmd_sector),
    .protect_map(protect_map), .erase_done(erase_done), .timer_closed(timer_closed),
    .busy(busy), .sector_mask(sector_mask), .erase_start(erase_start)
  );

  // behavioural reference: phase 0 idle, 1 collecting, 2 erasing
  int           m_phase = 0;
  int           m_left = 0;
  logic [N-1:0] m_mask = '0;
  bit           m_start = 0;

  always @(negedge rst_n) begin
    m_phase = 0; m_left = 0; m_mask = '0; m_start = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      logic [N-1:0] want;
      want = (N'(1) << cmd_sector) & ~protect_map;
      m_start = 0;
      if (m_phase == 0) begin
        if (cmd_valid) begin m_phase = 1; m_left = W; m_mask = want; end
      end else if (m_phase == 1) begin
        if (cmd_valid) begin
          m_left = W; m_mask = m_mask | want;
        end else if (m_left == 1) begin
          if (m_mask != 0) begin m_phase = 2; m_start = 1; end
          else m_phase = 0;
        end else m_left = m_left - 1;
      end else if (erase_done) begin
        m_phase = 0; m_mask = '0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(sector_mask == m_mask, "R3 mask", int'(sector_mask), int'(m_mask));
      check(timer_closed == (m_phase == 2), "R4 timer_closed", int'(timer_closed), int'(m_phase == 2));
      check(erase_start == m_start, "R4 erase_start", int'(erase_start), int'(m_start));
      check(busy == (m_phase != 0), "R2 busy", int'(busy), int'(m_phase != 0));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int s);
    cmd_valid = 1'b1; cmd_sector = 3'(s);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_done();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  initial begin
    tick(3);
    check(sector_mask == 0 && !busy && !timer_closed && !erase_start, "R1 reset", int'(sector_mask), 0);
    rst_n = 1'b1;
    tick(2);

    // single sector, close, erase, finish
    send(3);
    check(busy && !timer_closed, "R2 busy after first", int'({busy, timer_closed}), 2);
    check(sector_mask == 8'h08, "R3 first bit", int'(sector_mask), 8'h08);
    tick(W - 1);
    check(!timer_closed, "R4 still open", int'(timer_closed), 0);
    tick(1);
    check(timer_closed && erase_start, "R4 close+start", int'({timer_closed, erase_start}), 3);
    send(5);
    check(sector_mask == 8'h08 && !erase_start, "R5 ignored in erase", int'(sector_mask), 8'h08);
    tick(3);
    pulse_done();
    check(!busy && !timer_closed && sector_mask == 0, "R6 done", int'({busy, sector_mask}), 0);
    tick(2);

    // boundary gap, protected sector, done ignored while open
    protect_map = 8'h04;
    send(1);
    tick(W - 1);
    send(2);
    check(!timer_closed && sector_mask == 8'h02, "R7 protected skipped", int'(sector_mask), 8'h02);
    pulse_done();
    check(busy && sector_mask == 8'h02, "R9 done while open", int'({busy, sector_mask}), 9'h102);
    send(6);
    check(sector_mask == 8'h42, "R3 accumulate", int'(sector_mask), 8'h42);
    tick(W);
    check(erase_start && sector_mask == 8'h42, "R4 start multi", int'(sector_mask), 8'h42);
    pulse_done();
    pulse_done();
    check(!busy, "R9 done while idle", int'(busy), 0);

    // only protected sectors: no erase
    protect_map = 8'hFF;
    send(0);
    check(busy && sector_mask == 0, "R7 all protected", int'({busy, sector_mask}), 9'h100);
    begin
      bit seen = 0;
      for (int i = 0; i < W + 2; i++) begin
        @(negedge clk);
        if (erase_start) seen = 1;
      end
      check(!seen && !busy, "R8 empty window", int'({seen, busy}), 0);
    end
    protect_map = 8'h00;

    // reset mid-window
    send(4);
    tick(2);
    rst_n = 1'b0;
    #1;
    check(!busy && sector_mask == 0 && !erase_start, "R1 reset mid-window", int'({busy, sector_mask}), 0);
    tick(2);
    rst_n = 1'b1;
    tick(2);
    send(7);
    tick(W);
    check(erase_start && sector_mask == 8'h80, "R4 after reset", int'(sector_mask), 8'h80);
    pulse_done();
    tick(2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule